// File: doc/BRIEF.md
# Pulse-Width Burst Message Codec

This block exchanges short capability messages between two link partners while a port is matching its capabilities during polling. The partners enter that matching phase after a training-sequence error in the active or configuration polling phase. Each side announces what it supports, so that the fastest rate both can run is picked. Every message bit occupies one fixed bit period. The bit value is carried by the share of that period spent in low-frequency burst signalling rather than in electrical idle. A zero is a short burst of about one third of the period. A one is a long burst of about two thirds of the period.

The transmit half takes a message word and a start strobe. It then drives a burst-enable output one bit period at a time, most significant bit first. The receive half watches a burst-detect input, times each burst and each idle gap, and shifts the decoded bits into a word. At the end it pulses a valid flag with the whole word. If any interval is out of range, it pulses an error flag and drops the partial message instead. The bit period is a run-time input counted in clock cycles. The message length is a parameter and must be at least 2. The analog signalling, squelch detection and any use of the decoded capabilities lie outside the block.

Top module: `pwm_msg_codec`

## Requirements
- R1: While reset is held low, tx_busy, burst_en, rx_valid and rx_error are all 0.
- R2: A start sampled while idle raises tx_busy on the next cycle. tx_busy then stays high for exactly MSG_BITS × P cycles, where P is bit_period, and burst_en is 0 whenever tx_busy is 0.
- R3: Within each transmitted bit period, burst_en is high for the first T cycles and low for the rest. T = floor((P+1)/3) for a 0 bit and T = floor((2P+1)/3) for a 1 bit (each is the rounded third or two thirds).
- R4: The transmitter sends tx_word most significant bit first. The receiver places the first received bit in the most significant bit of rx_word.
- R5: A start strobe while tx_busy is high is ignored, and the message already in flight keeps its timing and content.
- R6: A received burst is decoded as 1 when its length in cycles exceeds floor(P/2), and as 0 otherwise. After the falling edge of the last burst of a message, rx_valid pulses for one cycle with the full word on rx_word.
- R7: A burst shorter than floor(P/6) cycles causes a one-cycle rx_error pulse, and the partial message is discarded.
- R8: A burst longer than P + floor(P/2) cycles causes a one-cycle rx_error pulse.
- R9: An idle gap between two bits of one message that is shorter than floor(P/6) cycles, or longer than P + floor(P/2) cycles, causes a one-cycle rx_error pulse.
- R10: After an error the receiver waits for burst-detect to go low, reports nothing further for that message, and decodes a fresh message starting at the next rising edge.
- R11: rx_valid and rx_error are never high in the same cycle, and each report is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_period | input | PER_W | Bit period P in clock cycles (at least 6) |
| tx_start | input | 1 | Start strobe for a message |
| tx_word | input | MSG_BITS | Message to send, sampled with the start |
| tx_busy | output | 1 | High while a message is being sent |
| burst_en | output | 1 | Enables burst signalling on the line |
| rx_burst | input | 1 | Burst-detect from the squelch circuit |
| rx_word | output | MSG_BITS | Last received message |
| rx_valid | output | 1 | One-cycle pulse: rx_word is complete |
| rx_error | output | 1 | One-cycle pulse: timing violation, message dropped |

## Verification
The bench builds the codec with MSG_BITS = 8 and PER_W = 8, so a full message lasts under a hundred cycles and many messages fit in one run. Looping the transmitter back into the receiver at bit periods of 10, 11 and 12 covers every rounding case of the one-third and two-thirds points: exact, rounded up and rounded down. Driving the detect input directly at P = 12 places bursts and gaps exactly on the decode boundary (6 and 7 cycles) and on the legal limits (2 and 18 cycles). It also places them one cycle past each limit, to trigger every error path and the recovery that follows.

// File: rtl/pwm_msg_codec.sv
module pwm_msg_codec #(
  parameter int MSG_BITS = 20,
  parameter int PER_W    = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PER_W-1:0]    bit_period,
  input  logic                tx_start,
  input  logic [MSG_BITS-1:0] tx_word,
  output logic                tx_busy,
  output logic                burst_en,
  input  logic                rx_burst,
  output logic [MSG_BITS-1:0] rx_word,
  output logic                rx_valid,
  output logic                rx_error
);

  localparam int BW = $clog2(MSG_BITS + 1);
  localparam int CW = PER_W + 1;
  localparam int XW = PER_W + 2;
  localparam logic [BW-1:0]    LAST_BIT = BW'(MSG_BITS - 1);
  localparam logic [BW-1:0]    ALL_BITS = BW'(MSG_BITS);
  localparam logic [BW-1:0]    B_ONE    = BW'(1);
  localparam logic [PER_W-1:0] P_ONE    = PER_W'(1);
  localparam logic [XW-1:0]    X_ONE    = XW'(1);
  localparam logic [XW-1:0]    X_THREE  = XW'(3);
  localparam logic [CW-1:0]    C_ONE    = CW'(1);
  localparam logic [CW-1:0]    C_SIX    = CW'(6);

  // transmit
  logic [MSG_BITS-1:0] tx_sr;
  logic [BW-1:0]       tx_left;
  logic [PER_W-1:0]    tx_cnt;

  wire [XW-1:0] p_x     = {2'b00, bit_period};
  wire [XW-1:0] third   = (p_x + X_ONE) / X_THREE;
  wire [XW-1:0] two3    = ({1'b0, bit_period, 1'b0} + X_ONE) / X_THREE;
  wire [XW-1:0] tx_thr  = tx_sr[MSG_BITS-1] ? two3 : third;
  wire          tx_wrap = (tx_cnt == bit_period - P_ONE);

  assign burst_en = tx_busy && ({2'b00, tx_cnt} < tx_thr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_busy <= 1'b0;
      tx_sr   <= '0;
      tx_left <= '0;
      tx_cnt  <= '0;
    end else if (!tx_busy) begin
      if (tx_start) begin
        tx_busy <= 1'b1;
        tx_sr   <= tx_word;
        tx_left <= ALL_BITS;
        tx_cnt  <= '0;
      end
    end else if (tx_wrap) begin
      tx_cnt  <= '0;
      tx_sr   <= tx_sr << 1;
      tx_left <= tx_left - B_ONE;
      if (tx_left == B_ONE) tx_busy <= 1'b0;
    end else begin
      tx_cnt <= tx_cnt + P_ONE;
    end
  end

  // receive
  typedef enum logic [1:0] {RX_IDLE, RX_HI, RX_LO, RX_DRAIN} rx_st_t;
  rx_st_t              rx_st;
  logic [CW-1:0]       r_cnt;
  logic [MSG_BITS-1:0] r_sr;
  logic [BW-1:0]       r_bits;

  wire [CW-1:0] p_c     = {1'b0, bit_period};
  wire [CW-1:0] min_len = p_c / C_SIX;
  wire [CW-1:0] max_len = p_c + (p_c >> 1);
  wire [CW-1:0] half    = p_c >> 1;
  wire [CW-1:0] r_inc   = r_cnt + C_ONE;
  wire [MSG_BITS-1:0] r_next = {r_sr[MSG_BITS-2:0], (r_cnt > half)};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_st    <= RX_IDLE;
      r_cnt    <= '0;
      r_sr     <= '0;
      r_bits   <= '0;
      rx_word  <= '0;
      rx_valid <= 1'b0;
      rx_error <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      rx_error <= 1'b0;
      case (rx_st)
        RX_IDLE: if (rx_burst) begin
          rx_st  <= RX_HI;
          r_cnt  <= C_ONE;
          r_bits <= '0;
        end
        RX_HI: if (rx_burst) begin
          if (r_inc > max_len) begin
            rx_error <= 1'b1;
            rx_st    <= RX_DRAIN;
          end else r_cnt <= r_inc;
        end else if (r_cnt < min_len) begin
          rx_error <= 1'b1;
          rx_st    <= RX_IDLE;
        end else if (r_bits == LAST_BIT) begin
          rx_word  <= r_next;
          rx_valid <= 1'b1;
          rx_st    <= RX_IDLE;
        end else begin
          r_sr   <= r_next;
          r_bits <= r_bits + B_ONE;
          r_cnt  <= C_ONE;
          rx_st  <= RX_LO;
        end
        RX_LO: if (!rx_burst) begin
          if (r_inc > max_len) begin
            rx_error <= 1'b1;
            rx_st    <= RX_DRAIN;
          end else r_cnt <= r_inc;
        end else if (r_cnt < min_len) begin
          rx_error <= 1'b1;
          rx_st    <= RX_DRAIN;
        end else begin
          r_cnt <= C_ONE;
          rx_st <= RX_HI;
        end
        default: if (!rx_burst) rx_st <= RX_IDLE;
      endcase
    end
  end

  // R2
  start_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_start && !tx_busy) |=> (tx_busy && burst_en));

  // R5
  start_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && tx_start && !tx_wrap) |=> $stable(tx_sr));

  // R11
  report_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid && rx_error));

  // R11
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R7
  err_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_error |=> !rx_valid);

endmodule

// File: tb/test_pwm_msg_codec.sv
module test_pwm_msg_codec;
  localparam int MB = 8;
  localparam int PW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [PW-1:0] bit_period = PW'(12);
  logic tx_start = 1'b0;
  logic [MB-1:0] tx_word = '0;
  logic tx_busy, burst_en, rx_valid, rx_error;
  logic [MB-1:0] rx_word;
  logic loop = 1'b1;
  logic rx_drv = 1'b0;
  wire  rx_in = loop ? burst_en : rx_drv;

  int checks = 0;
  int errors = 0;
  logic [MB:0] exp_q[$];

  always #2 clk = ~clk;

  pwm_msg_codec #(.MSG_BITS(MB), .PER_W(PW)) i_pwm_msg_codec (
    .clk(clk), .rst_n(rst_n), .bit_period(bit_period),
    .tx_start(tx_start), .tx_word(tx_word), .tx_busy(tx_busy),
    .burst_en(burst_en), .rx_burst(rx_in), .rx_word(rx_word),
    .rx_valid(rx_valid), .rx_error(rx_error));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected reports
  always @(negedge clk) begin
    if (rst_n && (rx_valid || rx_error)) begin
      chk(!(rx_valid && rx_error), "R11 both flags", {rx_valid, rx_error}, 0);
      if (exp_q.size() == 0) begin
        chk(1'b0, "R10 unexpected report", {rx_error, rx_word}, 0);
      end else begin
        logic [MB:0] e;
        logic [MB:0] a;
        e = exp_q.pop_front();
        a = rx_error ? {1'b1, {MB{1'b0}}} : {1'b0, rx_word};
        chk(a == e, e[MB] ? "R7/R8/R9 error report" : "R4/R6 received word", int'(a), int'(e));
      end
    end
  end

  task automatic tx_send(input logic [MB-1:0] w, input int per, input int bad_k);
    loop = 1'b1;
    bit_period = PW'(per);
    exp_q.push_back({1'b0, w});
    @(negedge clk);
    tx_word = w;
    tx_start = 1'b1;
    @(negedge clk);
    tx_start = 1'b0;
    for (int k = 0; k < MB * per; k++) begin
      int ph;
      int thr;
      logic b;
      b = w[MB - 1 - k / per];
      ph = k % per;
      thr = b ? (2 * per + 1) / 3 : (per + 1) / 3;
      if (k == bad_k) begin
        tx_start = 1'b1;
        tx_word = ~w;
      end
      chk(burst_en == (ph < thr), "R3/R4/R5 burst pattern", burst_en, ph < thr);
      chk(tx_busy == 1'b1, "R2 busy during message", tx_busy, 1);
      @(negedge clk);
      tx_start = 1'b0;
      tx_word = w;
    end
    chk(tx_busy == 1'b0, "R2 busy ends", tx_busy, 0);
    chk(burst_en == 1'b0, "R2 burst off when idle", burst_en, 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic rx_seg(input int hi, input int lo);
    rx_drv = 1'b1;
    repeat (hi) @(negedge clk);
    rx_drv = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  task automatic rx_msg(input logic [MB-1:0] w, input int h1, input int l1,
                        input int h0, input int l0);
    loop = 1'b0;
    exp_q.push_back({1'b0, w});
    for (int i = MB - 1; i >= 0; i--) begin
      if (w[i]) rx_seg(h1, l1);
      else rx_seg(h0, l0);
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(tx_busy == 1'b0, "R1 tx_busy in reset", tx_busy, 0);
    chk(burst_en == 1'b0, "R1 burst_en in reset", burst_en, 0);
    chk(rx_valid == 1'b0, "R1 rx_valid in reset", rx_valid, 0);
    chk(rx_error == 1'b0, "R1 rx_error in reset", rx_error, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // loopback, rounding at P = 12, 10, 11; start while busy at k = 30
    tx_send(8'hA5, 12, 30);
    tx_send(8'h3C, 10, MB * 10 - 1);
    tx_send(8'hFF, 11, 5);
    tx_send(8'h00, 11, -1);
    tx_send(8'h81, 12, -1);

    // direct drive at P = 12: decode boundary (R6) and legal limits
    bit_period = PW'(12);
    rx_msg(8'h96, 7, 5, 6, 6);
    rx_msg(8'h69, 18, 2, 2, 18);

    // R7 short burst after three bits
    exp_q.push_back({1'b1, {MB{1'b0}}});
    rx_seg(7, 5); rx_seg(7, 5); rx_seg(3, 9);
    rx_seg(1, 20);

    // R8 long burst, held well past the limit; R10 no second report
    exp_q.push_back({1'b1, {MB{1'b0}}});
    rx_seg(7, 5);
    rx_seg(25, 10);

    // R9 short gap
    exp_q.push_back({1'b1, {MB{1'b0}}});
    rx_seg(7, 1);
    rx_seg(7, 10);

    // R9 long gap
    exp_q.push_back({1'b1, {MB{1'b0}}});
    rx_seg(4, 19);
    repeat (5) @(negedge clk);

    // R10 recovery
    rx_msg(8'h5A, 8, 4, 4, 8);

    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R6/R10 all reports seen", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule